// File: doc/BRIEF.md
# Flash Security Lockout Recovery Controller

This block sits next to a JTAG TAP state machine and a flash controller. It decides whether a flash read coming in through the debug port may proceed. Boundary scan and the ID register are not routed through it and stay usable. It also runs a mass-erase recovery when a dedicated public recovery instruction is selected in the TAP. The recovery loads a 7-bit erase clock divider through a data register. It asks the flash for a mass erase only when the TAP enters Run-Test/Idle after that register has been updated. The erase counts as complete only if the TAP is still in Run-Test/Idle when the flash reports done.

Security is sampled into a held status bit and changes only at reset. The bit is first loaded at power-on reset. Two events can make the device leave the secure state. One is a completed mass erase. The other is a program write of data 0x0000 to flash address 0x007FF7. Either event only arms the unlock. The device becomes unsecured after the TAP has been reset and a device reset has then occurred, or after a power-on reset.

Top module: `fsr_top`

## Requirements
- R1: At power-on reset (porN low) secureStatus loads 1 when cfgWord equals SECURE_KEY (default 16'hA5C3) and 0 otherwise. dbgReadBlock is high exactly when dbgReadReq is high and secureStatus is 1.
- R2: While irRecoverSel and drShift are both high, each clock shifts tdi into a 7-bit register, least significant bit first. A clock with irRecoverSel and drUpdate high copies that register to eraseDiv. Shift or update strobes seen while irRecoverSel is low have no effect on eraseDiv.
- R3: eraseReq rises on the clock after tapInIdle and irRecoverSel are seen high, but only once a recovery data update has occurred.
- R4: After an erase completes or is aborted, entering Run-Test/Idle again without a fresh recovery update does not raise eraseReq.
- R5: If tapInIdle drops while eraseReq is high, eraseReq falls on the next clock. eraseDone stays 0, and the abort does not arm an unlock.
- R6: flashDone seen while eraseReq and tapInIdle are high drops eraseReq and sets eraseDone on the next clock. eraseDone holds until tapInReset is seen high.
- R7: While an erase runs, neither shifts nor updates change eraseDiv.
- R8: A completed erase leaves secureStatus unchanged until tapInReset has been seen and a device reset (sysRstN low) then follows. A device reset without the TAP reset keeps the device secure.
- R9: A flash write with address 0x007FF7 and data 0x0000 arms the unlock in the same way as R8. Writes of other data, or to other addresses, arm nothing.
- R10: A device reset with no unlock armed reloads secureStatus from cfgWord.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, asynchronous, active low |
| sysRstN | input | 1 | Device reset, sampled synchronously, active low |
| tapInReset | input | 1 | TAP is in Test-Logic-Reset |
| tapInIdle | input | 1 | TAP is in Run-Test/Idle |
| irRecoverSel | input | 1 | Instruction register decodes to the recovery instruction |
| drShift | input | 1 | Data-register shift strobe |
| drUpdate | input | 1 | Data-register update strobe |
| tdi | input | 1 | Serial test data in |
| flashDone | input | 1 | Flash reports that the mass erase has finished |
| flashWrEn | input | 1 | A flash program write is observed |
| flashWrAddr | input | 24 | Address of the observed write |
| flashWrData | input | 16 | Data of the observed write |
| cfgWord | input | 16 | Configuration protection word read from flash |
| dbgReadReq | input | 1 | Debug port requests a flash read |
| dbgReadBlock | output | 1 | Debug flash read is refused |
| eraseReq | output | 1 | Mass-erase request to the flash |
| eraseDiv | output | 7 | Erase clock divider that goes with eraseReq |
| eraseDone | output | 1 | Sticky flag: a recovery erase has completed |
| secureStatus | output | 1 | Held security state |

## Verification
The bench goes after the ordering rules of the recovery sequence. One test re-enters Run-Test/Idle with no new update; a design that restarted the erase would raise eraseReq again there. Another test leaves Idle in the middle of an erase; a design that treated this as success would set eraseDone or unlock the device. A third test shifts a new divider while an erase runs; a design that let it through would change eraseDiv. The bench also separates the two resets: a device that unlocked on a device reset alone, or at the moment of completion, would show secureStatus low too early. For the unlock write it tries near-miss addresses and data, which a loose decoder would accept.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_ERASE = 2'd2,
    ST_DONE  = 2'd3
  } recovState_t;

  typedef struct packed {
    logic shiftEn;
    logic latchEn;
  } dpStrobe_t;

endpackage

// File: rtl/fsr_datapath.sv
module fsr_datapath
  import fsr_pkg::*;
#(
  parameter int DIV_W = 7,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 24'h007FF7,
  parameter logic [DATA_W-1:0] UNLOCK_DATA = 16'h0000,
  parameter logic [DATA_W-1:0] SECURE_KEY = 16'hA5C3
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              tdi,
  input  dpStrobe_t         strobe,
  input  logic              flashWrEn,
  input  logic [ADDR_W-1:0] flashWrAddr,
  input  logic [DATA_W-1:0] flashWrData,
  input  logic [DATA_W-1:0] cfgWord,
  output logic [DIV_W-1:0]  eraseDiv,
  output logic              unlockWrite,
  output logic              cfgIsKey
);

  logic [DIV_W-1:0] shiftReg;
  logic [DIV_W-1:0] divReg;

  // Serial capture, first bit ends at bit 0
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      shiftReg <= '0;
    end else if (strobe.shiftEn) begin
      shiftReg <= {tdi, shiftReg[DIV_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      divReg <= '0;
    end else if (strobe.latchEn) begin
      divReg <= shiftReg;
    end
  end

  assign eraseDiv    = divReg;
  assign unlockWrite = flashWrEn && (flashWrAddr == UNLOCK_ADDR)
                       && (flashWrData == UNLOCK_DATA);
  assign cfgIsKey    = (cfgWord == SECURE_KEY);

endmodule

// File: rtl/fsr_control.sv
module fsr_control
  import fsr_pkg::*;
(
  input  logic      clk,
  input  logic      porN,
  input  logic      sysRstN,
  input  logic      tapInReset,
  input  logic      tapInIdle,
  input  logic      irRecoverSel,
  input  logic      drShift,
  input  logic      drUpdate,
  input  logic      flashDone,
  input  logic      unlockWrite,
  input  logic      cfgIsKey,
  output dpStrobe_t strobe,
  output logic      eraseReq,
  output logic      eraseDone,
  output logic      secureStatus
);

  recovState_t state, stateNext;
  logic unlockArmed;
  logic tapCleared;
  logic eraseOk;
  logic inRecovIdle;

  assign inRecovIdle = tapInIdle && irRecoverSel;
  assign eraseOk     = (state == ST_ERASE) && inRecovIdle && flashDone;

  always_comb begin
    strobe.shiftEn = irRecoverSel && drShift;
    strobe.latchEn = irRecoverSel && drUpdate && (state != ST_ERASE);
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE, ST_DONE: if (strobe.latchEn) stateNext = ST_ARMED;
      ST_ARMED: if (!strobe.latchEn && inRecovIdle) stateNext = ST_ERASE;
      ST_ERASE: begin
        if (!inRecovIdle) stateNext = ST_IDLE;
        else if (flashDone) stateNext = ST_DONE;
      end
      default: stateNext = ST_IDLE;
    endcase
    if (tapInReset) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      eraseDone <= 1'b0;
    end else if (tapInReset) begin
      eraseDone <= 1'b0;
    end else if (eraseOk) begin
      eraseDone <= 1'b1;
    end
  end

  // Security bookkeeping: unlock applies only after TAP reset then device reset
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      secureStatus <= cfgIsKey;
      unlockArmed  <= 1'b0;
      tapCleared   <= 1'b0;
    end else if (!sysRstN) begin
      if (unlockArmed && tapCleared) begin
        secureStatus <= 1'b0;
        unlockArmed  <= 1'b0;
        tapCleared   <= 1'b0;
      end else if (!unlockArmed) begin
        secureStatus <= cfgIsKey;
      end
    end else begin
      if (eraseOk || unlockWrite) unlockArmed <= 1'b1;
      if (tapInReset && unlockArmed) tapCleared <= 1'b1;
    end
  end

  assign eraseReq = (state == ST_ERASE);

endmodule

// File: rtl/fsr_top.sv
module fsr_top
  import fsr_pkg::*;
#(
  parameter int DIV_W = 7,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 24'h007FF7,
  parameter logic [DATA_W-1:0] UNLOCK_DATA = 16'h0000,
  parameter logic [DATA_W-1:0] SECURE_KEY = 16'hA5C3
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              sysRstN,
  input  logic              tapInReset,
  input  logic              tapInIdle,
  input  logic              irRecoverSel,
  input  logic              drShift,
  input  logic              drUpdate,
  input  logic              tdi,
  input  logic              flashDone,
  input  logic              flashWrEn,
  input  logic [ADDR_W-1:0] flashWrAddr,
  input  logic [DATA_W-1:0] flashWrData,
  input  logic [DATA_W-1:0] cfgWord,
  input  logic              dbgReadReq,
  output logic              dbgReadBlock,
  output logic              eraseReq,
  output logic [DIV_W-1:0]  eraseDiv,
  output logic              eraseDone,
  output logic              secureStatus
);

  dpStrobe_t strobe;
  logic unlockWrite;
  logic cfgIsKey;

  fsr_datapath #(
    .DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .UNLOCK_ADDR(UNLOCK_ADDR), .UNLOCK_DATA(UNLOCK_DATA), .SECURE_KEY(SECURE_KEY)
  ) uDp (
    .clk(clk), .porN(porN), .tdi(tdi), .strobe(strobe),
    .flashWrEn(flashWrEn), .flashWrAddr(flashWrAddr), .flashWrData(flashWrData),
    .cfgWord(cfgWord), .eraseDiv(eraseDiv), .unlockWrite(unlockWrite),
    .cfgIsKey(cfgIsKey)
  );

  fsr_control uCtrl (
    .clk(clk), .porN(porN), .sysRstN(sysRstN), .tapInReset(tapInReset),
    .tapInIdle(tapInIdle), .irRecoverSel(irRecoverSel), .drShift(drShift),
    .drUpdate(drUpdate), .flashDone(flashDone), .unlockWrite(unlockWrite),
    .cfgIsKey(cfgIsKey), .strobe(strobe), .eraseReq(eraseReq),
    .eraseDone(eraseDone), .secureStatus(secureStatus)
  );

  assign dbgReadBlock = dbgReadReq && secureStatus;

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
  parameter int DIV_W = 7
) (
  input logic             clk,
  input logic             porN,
  input logic             sysRstN,
  input logic             tapInReset,
  input logic             tapInIdle,
  input logic             dbgReadReq,
  input logic             dbgReadBlock,
  input logic             eraseReq,
  input logic [DIV_W-1:0] eraseDiv,
  input logic             eraseDone,
  input logic             secureStatus
);

  // R1: a refusal only ever answers a real debug read
  a_r1_block_needs_req: assert property (@(posedge clk) disable iff (!porN)
    dbgReadBlock |-> dbgReadReq);

  // R3: a new request appears only after Idle was seen
  a_r3_req_after_idle: assert property (@(posedge clk) disable iff (!porN)
    $rose(eraseReq) |-> $past(tapInIdle));

  // R5: leaving Idle drops the request
  a_r5_abort_drops_req: assert property (@(posedge clk) disable iff (!porN)
    (eraseReq && !tapInIdle) |=> !eraseReq);

  // R6: completion flag holds until TAP reset
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!porN)
    (eraseDone && !tapInReset) |=> eraseDone);

  // R7: divider frozen while an erase runs
  a_r7_div_frozen: assert property (@(posedge clk) disable iff (!porN)
    (eraseReq && $past(eraseReq)) |-> $stable(eraseDiv));

  // R8: security moves only across a device reset
  a_r8_secure_held: assert property (@(posedge clk) disable iff (!porN)
    (sysRstN && $past(sysRstN)) |-> $stable(secureStatus));

endmodule

bind fsr_top fsr_checker #(.DIV_W(DIV_W)) uChk (
  .clk(clk), .porN(porN), .sysRstN(sysRstN), .tapInReset(tapInReset),
  .tapInIdle(tapInIdle), .dbgReadReq(dbgReadReq), .dbgReadBlock(dbgReadBlock),
  .eraseReq(eraseReq), .eraseDiv(eraseDiv), .eraseDone(eraseDone),
  .secureStatus(secureStatus)
);

// File: tb/tb_fsr_top.sv
module tb_fsr_top;

  localparam logic [15:0] KEY = 16'hA5C3;

  logic clk = 1'b0;
  logic porN, sysRstN, tapInReset, tapInIdle, irRecoverSel, drShift, drUpdate, tdi;
  logic flashDone, flashWrEn, dbgReadReq;
  logic [23:0] flashWrAddr;
  logic [15:0] flashWrData, cfgWord;
  logic dbgReadBlock, eraseReq, eraseDone, secureStatus;
  logic [6:0] eraseDiv;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fsr_top dut (
    .clk(clk), .porN(porN), .sysRstN(sysRstN), .tapInReset(tapInReset),
    .tapInIdle(tapInIdle), .irRecoverSel(irRecoverSel), .drShift(drShift),
    .drUpdate(drUpdate), .tdi(tdi), .flashDone(flashDone), .flashWrEn(flashWrEn),
    .flashWrAddr(flashWrAddr), .flashWrData(flashWrData), .cfgWord(cfgWord),
    .dbgReadReq(dbgReadReq), .dbgReadBlock(dbgReadBlock), .eraseReq(eraseReq),
    .eraseDiv(eraseDiv), .eraseDone(eraseDone), .secureStatus(secureStatus)
  );

  // {cfgWord, dbgReadReq, expected secureStatus, expected dbgReadBlock}
  localparam int NV = 5;
  localparam logic [18:0] VEC [NV] = '{
    {16'hA5C3, 1'b1, 1'b1, 1'b1},
    {16'hA5C3, 1'b0, 1'b1, 1'b0},
    {16'h0000, 1'b1, 1'b0, 1'b0},
    {16'hFFFF, 1'b1, 1'b0, 1'b0},
    {16'hA5C2, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idleInputs();
    sysRstN = 1; tapInReset = 0; tapInIdle = 0; irRecoverSel = 0;
    drShift = 0; drUpdate = 0; tdi = 0; flashDone = 0; flashWrEn = 0;
    flashWrAddr = '0; flashWrData = '0; dbgReadReq = 0;
  endtask

  task automatic powerOn(logic [15:0] cfg);
    idleInputs();
    cfgWord = cfg;
    porN = 0;
    tick();
    porN = 1;
    tick();
  endtask

  task automatic loadDiv(logic [6:0] val, logic sel);
    irRecoverSel = sel;
    for (int i = 0; i < 7; i++) begin
      drShift = 1; tdi = val[i];
      tick();
    end
    drShift = 0; drUpdate = 1;
    tick();
    drUpdate = 0;
    irRecoverSel = 1;
  endtask

  task automatic tapReset();
    tapInIdle = 0; tapInReset = 1; tick(); tapInReset = 0; tick();
  endtask

  task automatic devReset();
    sysRstN = 0; tick(); sysRstN = 1; tick();
  endtask

  task automatic flashWrite(logic [23:0] a, logic [15:0] d);
    flashWrEn = 1; flashWrAddr = a; flashWrData = d; tick(); flashWrEn = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFail++; nRun++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    idleInputs();
    cfgWord = KEY;
    porN = 0;
    tick();

    // R1 table
    for (int v = 0; v < NV; v++) begin
      powerOn(VEC[v][18:3]);
      dbgReadReq = VEC[v][2];
      tick();
      check("R1 secure", 32'(secureStatus), 32'(VEC[v][1]));
      check("R1 block", 32'(dbgReadBlock), 32'(VEC[v][0]));
    end

    // reset state
    powerOn(KEY);
    check("R1 reset eraseReq", 32'(eraseReq), 0);
    check("R6 reset eraseDone", 32'(eraseDone), 0);

    // R2 divider capture
    loadDiv(7'h5A, 1);
    check("R2 divider", 32'(eraseDiv), 32'h5A);
    check("R3 no req before idle", 32'(eraseReq), 0);
    loadDiv(7'h11, 0);
    check("R2 other instr ignored", 32'(eraseDiv), 32'h5A);

    // R3 erase starts
    tapInIdle = 1; tick();
    check("R3 req", 32'(eraseReq), 1);
    // R7 shift and update during erase
    for (int i = 0; i < 7; i++) begin drShift = 1; tdi = i[0]; tick(); end
    drShift = 0; drUpdate = 1; tick(); drUpdate = 0;
    check("R7 div frozen", 32'(eraseDiv), 32'h5A);
    check("R7 still erasing", 32'(eraseReq), 1);

    // R6 completion
    flashDone = 1; tick(); flashDone = 0;
    check("R6 req drops", 32'(eraseReq), 0);
    check("R6 done set", 32'(eraseDone), 1);
    tapInIdle = 0; tick(); tapInIdle = 1; tick(); tick();
    check("R4 no restart", 32'(eraseReq), 0);
    check("R6 done held", 32'(eraseDone), 1);

    // R8 reset ordering
    check("R8 still secure", 32'(secureStatus), 1);
    devReset();
    check("R8 device reset alone", 32'(secureStatus), 1);
    tapReset();
    check("R6 done cleared", 32'(eraseDone), 0);
    check("R8 before device reset", 32'(secureStatus), 1);
    devReset();
    dbgReadReq = 1; tick();
    check("R8 unsecured", 32'(secureStatus), 0);
    check("R1 read allowed", 32'(dbgReadBlock), 0);

    // R5 abort
    powerOn(KEY);
    loadDiv(7'h33, 1);
    tapInIdle = 1; tick();
    check("R5 started", 32'(eraseReq), 1);
    tapInIdle = 0; tick();
    check("R5 req drops", 32'(eraseReq), 0);
    check("R5 no done", 32'(eraseDone), 0);
    tapInIdle = 1; tick(); tick();
    check("R4 no restart after abort", 32'(eraseReq), 0);
    flashDone = 1; tick(); flashDone = 0;
    check("R5 late done ignored", 32'(eraseDone), 0);
    tapReset(); devReset();
    check("R5 abort keeps secure", 32'(secureStatus), 1);

    // R9 unlock write
    powerOn(KEY);
    flashWrite(24'h007FF7, 16'h0001);
    flashWrite(24'h007FF6, 16'h0000);
    tapReset(); devReset();
    check("R9 near misses", 32'(secureStatus), 1);
    flashWrite(24'h007FF7, 16'h0000);
    tick();
    check("R9 not immediate", 32'(secureStatus), 1);
    tapReset(); devReset();
    check("R9 unlocked", 32'(secureStatus), 0);

    // R10 resample on device reset
    powerOn(16'h1234);
    check("R10 unsecure at por", 32'(secureStatus), 0);
    cfgWord = KEY;
    devReset();
    check("R10 resampled", 32'(secureStatus), 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule